// File: doc/BRIEF.md
# Loopback Receive Buffer with Circulating Write Pointer

This block is the receive side of a small byte buffer inside a half-duplex network controller. In loopback diagnostics the controller's 16-byte buffer is split in two: one 8-byte half feeds the transmitter and the other 8-byte half, the part built here, collects the frame that comes back around. Received bytes are written into an 8-entry ring whose write pointer wraps and overwrites. The ring keeps going around until the frame ends. Then the block writes three more entries: the low byte of an 11-bit received-byte count, and the high byte twice. Only the last five frame bytes and the count survive, and a host can check them through one read port.

The host reads the ring one byte per read strobe. The read pointer starts at entry 0 and wraps after entry 7. Reads have meaning only in loopback. Outside loopback the port returns zero and nothing in the block moves. Each new enable of loopback realigns both pointers to entry 0 before the next frame. A frame of length 8N+5 therefore lands with byte 8N+1 at entry 0 and the count bytes at entries 5, 6 and 7.

Top module: `lbk_rx_fifo`

## Requirements
- R1: After reset all eight entries hold 0x00, `rd_valid` is 0, and with loopback off `rd_data` is 0x00.
- R2: While loopback is on and a frame is open, the k-th accepted byte (k counted from 1) is written to entry (k-1) mod 8, overwriting whatever was there.
- R3: When the frame ends, the three entries that follow the last byte, in ring order, receive count[7:0], then {5'b0, count[10:8]}, then {5'b0, count[10:8]} again. `rd_valid` goes high exactly three cycles after the clock edge that accepts the end-of-frame.
- R4: The byte count is 11 bits wide and wraps to 0 after 2047, so a frame of L bytes reports L mod 2048.
- R5: A byte strobe given in the same cycle as `rx_eof` is stored and counted as the final byte of the frame. A lone `rx_eof` ends the frame with no further byte.
- R6: Once a frame has ended, further `rx_stb` and `rx_eof` are ignored until loopback is enabled again.
- R7: With loopback on, `rd_data` shows the entry at the read pointer. Each `rd_stb` advances the pointer by one, and after entry 7 it returns to entry 0.
- R8: A rising edge of `lpbk_en` (or reset) sets the write pointer, the read pointer and the count to 0 and reopens frame reception. Stored bytes are kept. During that first enabled cycle the read port shows entry 0 and ignores `rd_stb`.
- R9: With loopback off, `rd_data` is 0x00, and `rd_stb`, `rx_stb` and `rx_eof` change neither the stored bytes nor the pointers.
- R10: `rd_valid` is high only while loopback is on and the count bytes of the current frame have all been written. It is low while a frame is still being received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lpbk_en | input | 1 | Loopback mode enable; each rising edge realigns pointers |
| rx_stb | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | End-of-frame pulse |
| rd_stb | input | 1 | Host read strobe, advances the read pointer |
| rd_data | output | 8 | Byte at the read pointer, 0x00 outside loopback |
| rd_valid | output | 1 | Frame tail and count ready to read |

## Verification
Frames of 13, 5, 7, 3, 1000 and 2053 bytes are sent. The 13-byte frame checks the 8N+5 placement after one full wrap. The 5-byte frame shows placement with no wrap. The 7-byte frame makes the count bytes themselves wrap to entries 0 and 1. The 3-byte frame uses a coincident end strobe and leaves stale entries that must survive. The 1000-byte frame gives a nonzero high count byte, and the 2053-byte frame must report 5 because the count wraps. Strobes after frame end, strobes and reads with loopback off, reads past entry 7 and a re-enable after a partial read separate the ignore, wrap and realignment rules from the plain write path.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

    // Frame reception phase of the receive half.
    typedef enum logic [1:0] {
        PH_RECV   = 2'd0,
        PH_APPEND = 2'd1,
        PH_DONE   = 2'd2
    } lbk_phase_e;

    // Which count byte the append sequence writes next.
    typedef enum logic [1:0] {
        AP_LOW    = 2'd0,
        AP_HIGH_A = 2'd1,
        AP_HIGH_B = 2'd2
    } lbk_app_e;

endpackage

// File: rtl/lbk_ctrl.sv
module lbk_ctrl
    import lbk_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RX_DEPTH = 8,
    parameter int CNT_W    = 11,
    localparam int PTR_W   = $clog2(RX_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lpbk_en,
    input  logic              rx_stb,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_eof,
    output logic              wr_en,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              clr,
    output logic              rd_valid,
    output lbk_phase_e        phase,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [CNT_W-1:0]  cnt,
    output logic              en_q
);

    typedef struct packed {
        lbk_phase_e        phase;
        lbk_app_e          app;
        logic [PTR_W-1:0]  wr_ptr;
        logic [CNT_W-1:0]  cnt;
        logic              en;
    } ctrl_s;

    ctrl_s st_q, st_d;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(RX_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic [DATA_W-1:0] cnt_lo_d, cnt_hi_d;
    assign cnt_lo_d = st_q.cnt[DATA_W-1:0];
    assign cnt_hi_d = DATA_W'(st_q.cnt >> DATA_W);

    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_addr = st_q.wr_ptr;
        wr_data = rx_data;
        clr     = lpbk_en && !st_q.en;
        st_d.en = lpbk_en;

        if (clr) begin
            st_d.wr_ptr = '0;
            st_d.cnt    = '0;
            st_d.phase  = PH_RECV;
            st_d.app    = AP_LOW;
        end else if (lpbk_en) begin
            unique case (st_q.phase)
                PH_RECV: begin
                    if (rx_stb) begin
                        wr_en       = 1'b1;
                        wr_data     = rx_data;
                        st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
                        st_d.cnt    = st_q.cnt + 1'b1;
                    end
                    if (rx_eof) begin
                        st_d.phase = PH_APPEND;
                        st_d.app   = AP_LOW;
                    end
                end
                PH_APPEND: begin
                    wr_en       = 1'b1;
                    wr_data     = (st_q.app == AP_LOW) ? cnt_lo_d : cnt_hi_d;
                    st_d.wr_ptr = ptr_inc(st_q.wr_ptr);
                    unique case (st_q.app)
                        AP_LOW:    st_d.app = AP_HIGH_A;
                        AP_HIGH_A: st_d.app = AP_HIGH_B;
                        default: begin
                            st_d.app   = AP_LOW;
                            st_d.phase = PH_DONE;
                        end
                    endcase
                end
                default: begin
                    st_d.phase = PH_DONE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_RECV, app: AP_LOW, wr_ptr: '0, cnt: '0, en: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = lpbk_en && st_q.en && (st_q.phase == PH_DONE);
    assign phase    = st_q.phase;
    assign wr_ptr   = st_q.wr_ptr;
    assign cnt      = st_q.cnt;
    assign en_q     = st_q.en;

endmodule

// File: rtl/lbk_store.sv
module lbk_store #(
    parameter int DATA_W   = 8,
    parameter int RX_DEPTH = 8,
    localparam int PTR_W   = $clog2(RX_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_word
);

    logic [DATA_W-1:0]   mem_q [RX_DEPTH];
    logic [DATA_W-1:0]   mem_d [RX_DEPTH];
    logic [RX_DEPTH-1:0] hit;

    for (genvar gi = 0; gi < RX_DEPTH; gi++) begin : g_slot
        assign hit[gi] = wr_en && (wr_addr == PTR_W'(gi));
    end

    always_comb begin
        for (int i = 0; i < RX_DEPTH; i++) begin
            mem_d[i] = hit[i] ? wr_data : mem_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < RX_DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < RX_DEPTH; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rd_word = mem_q[rd_addr];

endmodule

// File: rtl/lbk_rdport.sv
module lbk_rdport #(
    parameter int DATA_W   = 8,
    parameter int RX_DEPTH = 8,
    localparam int PTR_W   = $clog2(RX_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lpbk_en,
    input  logic              clr,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] rd_word,
    output logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [PTR_W-1:0]  rd_ptr
);

    typedef struct packed {
        logic [PTR_W-1:0] ptr;
    } rd_s;

    rd_s rp_q, rp_d;

    always_comb begin
        rp_d = rp_q;
        if (clr) begin
            rp_d.ptr = '0;
        end else if (lpbk_en && rd_stb) begin
            rp_d.ptr = (rp_q.ptr == PTR_W'(RX_DEPTH - 1)) ? '0 : rp_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rp_q <= '0;
        end else begin
            rp_q <= rp_d;
        end
    end

    assign rd_addr = clr ? '0 : rp_q.ptr;
    assign rd_data = lpbk_en ? rd_word : '0;
    assign rd_ptr  = rp_q.ptr;

endmodule

// File: rtl/lbk_rx_fifo.sv
module lbk_rx_fifo
    import lbk_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int RX_DEPTH = 8,
    parameter int CNT_W    = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lpbk_en,
    input  logic              rx_stb,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_eof,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int PTR_W = $clog2(RX_DEPTH);

    logic              wr_en;
    logic [PTR_W-1:0]  wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              clr;
    lbk_phase_e        phase;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [PTR_W-1:0]  rd_addr;
    logic [CNT_W-1:0]  cnt;
    logic              en_q;
    logic [DATA_W-1:0] rd_word;

    lbk_ctrl #(.DATA_W(DATA_W), .RX_DEPTH(RX_DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lpbk_en  (lpbk_en),
        .rx_stb   (rx_stb),
        .rx_data  (rx_data),
        .rx_eof   (rx_eof),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .clr      (clr),
        .rd_valid (rd_valid),
        .phase    (phase),
        .wr_ptr   (wr_ptr),
        .cnt      (cnt),
        .en_q     (en_q)
    );

    lbk_store #(.DATA_W(DATA_W), .RX_DEPTH(RX_DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_word (rd_word)
    );

    lbk_rdport #(.DATA_W(DATA_W), .RX_DEPTH(RX_DEPTH)) u_rdport (
        .clk     (clk),
        .rst_n   (rst_n),
        .lpbk_en (lpbk_en),
        .clr     (clr),
        .rd_stb  (rd_stb),
        .rd_word (rd_word),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .rd_ptr  (rd_ptr)
    );

endmodule

// File: rtl/lbk_rx_fifo_chk.sv
module lbk_rx_fifo_chk
    import lbk_pkg::*;
#(
    parameter int RX_DEPTH = 8,
    parameter int CNT_W    = 11,
    parameter int PTR_W    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lpbk_en,
    input logic             rx_stb,
    input logic             rx_eof,
    input logic             rd_stb,
    input logic             rd_valid,
    input logic             en_q,
    input lbk_phase_e       phase,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [CNT_W-1:0] cnt
);

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(RX_DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assert_byte_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk_en && en_q && phase == PH_RECV && rx_stb |=> wr_ptr == nxt($past(wr_ptr)));

    assert_append_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk_en && en_q && phase == PH_APPEND |=> wr_ptr == nxt($past(wr_ptr)));

    assert_count_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk_en && en_q && phase == PH_RECV && rx_stb && cnt == '1 |=> cnt == '0);

    assert_last_with_eof_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk_en && en_q && phase == PH_RECV && rx_stb && rx_eof
        |=> phase == PH_APPEND && cnt == $past(cnt) + 1'b1);

    assert_frozen_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> $stable(wr_ptr) && $stable(cnt));

    assert_read_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk_en && en_q && rd_stb |=> rd_ptr == nxt($past(rd_ptr)));

    assert_realign_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lpbk_en && !en_q |=> wr_ptr == '0 && rd_ptr == '0 && cnt == '0 && phase == PH_RECV);

    assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lpbk_en |=> $stable(wr_ptr) && $stable(rd_ptr) && $stable(cnt));

    assert_valid_needs_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> lpbk_en && phase == PH_DONE);

endmodule

bind lbk_rx_fifo lbk_rx_fifo_chk #(
    .RX_DEPTH (RX_DEPTH),
    .CNT_W    (CNT_W),
    .PTR_W    (PTR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lpbk_en  (lpbk_en),
    .rx_stb   (rx_stb),
    .rx_eof   (rx_eof),
    .rd_stb   (rd_stb),
    .rd_valid (rd_valid),
    .en_q     (en_q),
    .phase    (phase),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .cnt      (cnt)
);

// File: tb/lbk_rx_fifo_tb.sv
module lbk_rx_fifo_tb;

    localparam int DEPTH = 8;

    logic       clk = 1'b0;
    logic       rst_n, lpbk_en, rx_stb, rx_eof, rd_stb;
    logic [7:0] rx_data;
    logic [7:0] rd_data;
    logic       rd_valid;

    always #2 clk = ~clk;

    lbk_rx_fifo u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .lpbk_en  (lpbk_en),
        .rx_stb   (rx_stb),
        .rx_data  (rx_data),
        .rx_eof   (rx_eof),
        .rd_stb   (rd_stb),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    int         n_cmp = 0;
    int         n_bad = 0;
    bit         finished = 0;
    logic [7:0] model [DEPTH];
    int         rd_pos = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Monitor: pops one expected byte for every read strobe.
    always @(negedge clk) begin
        if (rst_n && rd_stb) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 scoreboard underrun", rd_data, 0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic reenable();
        lpbk_en = 1'b0;
        tick();
        lpbk_en = 1'b1;
        tick();
        rd_pos = 0;
    endtask

    // Driver: pushes the expected byte, then strobes one read.
    task automatic read_n(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(lpbk_en ? model[rd_pos] : 8'h00);
            tag_q.push_back(tag);
            rd_stb = 1'b1;
            tick();
            if (lpbk_en) rd_pos = (rd_pos + 1) % DEPTH;
        end
        rd_stb = 1'b0;
    endtask

    task automatic send_frame(input int len, input int start, input bit eof_on_last, input string tag);
        int c;
        int waited;
        reenable();
        for (int k = 1; k <= len; k++) begin
            rx_stb  = 1'b1;
            rx_data = 8'(start + k);
            rx_eof  = eof_on_last && (k == len);
            model[(k - 1) % DEPTH] = 8'(start + k);
            tick();
            if (k == 1 && len > 1) check(rd_valid == 1'b0, "R10 low mid-frame", rd_valid, 0);
        end
        rx_stb = 1'b0;
        rx_eof = 1'b0;
        if (!eof_on_last) begin
            rx_eof = 1'b1;
            tick();
            rx_eof = 1'b0;
        end
        c = len % 2048;
        model[len % DEPTH]       = 8'(c);
        model[(len + 1) % DEPTH] = 8'(c >> 8);
        model[(len + 2) % DEPTH] = 8'(c >> 8);
        waited = 0;
        while (!rd_valid && waited < 20) begin
            tick();
            waited++;
        end
        check(rd_valid == 1'b1, {tag, " R10 ready"}, rd_valid, 1);
        check(waited == 3, {tag, " R3 ready latency"}, waited, 3);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual hung expected finished");
            report();
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        rst_n = 1'b0; lpbk_en = 1'b0; rx_stb = 1'b0; rx_eof = 1'b0; rd_stb = 1'b0; rx_data = 8'h00;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: reset state
        check(rd_valid == 1'b0, "R1 rd_valid after reset", rd_valid, 0);
        check(rd_data == 8'h00, "R1 rd_data after reset", rd_data, 0);
        lpbk_en = 1'b1;
        tick();
        rd_pos = 0;
        read_n(8, "R1 storage cleared");

        // R2 R3: 13 = 8*1+5, byte 9 lands at entry 0, count at 5..7
        send_frame(13, 8'h10, 1'b0, "R2 len13");
        read_n(8, "R2 R3 len13 readback");
        // R3: no wrap
        send_frame(5, 8'h40, 1'b0, "R3 len5");
        read_n(8, "R3 len5 readback");
        // R3: count bytes wrap to entries 0 and 1
        send_frame(7, 8'h80, 1'b0, "R3 len7");
        read_n(8, "R3 len7 count wrap");
        // R5: eof with last byte; entries 6,7 keep stale data
        send_frame(3, 8'hA0, 1'b1, "R5 len3");
        read_n(8, "R5 len3 readback");
        // R4: high count byte nonzero
        send_frame(1000, 8'h05, 1'b0, "R4 len1000");
        read_n(8, "R4 len1000 readback");
        // R4: count rolls over at 2048
        send_frame(2053, 8'h33, 1'b1, "R4 len2053");
        read_n(8, "R4 len2053 readback");

        // R6: strobes after frame end are ignored
        rx_stb = 1'b1; rx_eof = 1'b1; rx_data = 8'hEE;
        repeat (3) tick();
        rx_stb = 1'b0; rx_eof = 1'b0;
        check(rd_valid == 1'b1, "R6 rd_valid kept", rd_valid, 1);
        read_n(8, "R6 content unchanged");

        // R7: read pointer wraps after entry 7
        read_n(10, "R7 read wrap");

        // R8: partial read then re-enable realigns to entry 0
        read_n(3, "R8 partial");
        reenable();
        check(rd_valid == 1'b0, "R8 frame reopened", rd_valid, 0);
        read_n(8, "R8 realigned readback");

        // R9: loopback off
        lpbk_en = 1'b0;
        tick();
        check(rd_valid == 1'b0, "R9 R10 rd_valid off", rd_valid, 0);
        read_n(3, "R9 reads zero");
        rx_stb = 1'b1; rx_data = 8'h5A;
        repeat (4) tick();
        rx_eof = 1'b1;
        tick();
        rx_stb = 1'b0; rx_eof = 1'b0;
        lpbk_en = 1'b1;
        tick();
        rd_pos = 0;
        read_n(8, "R9 storage untouched");

        repeat (3) tick();
        check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
        finished = 1;
        report();
    end

endmodule